// File: doc/BRIEF.md
# Half-Precision Vector Pack/Unpack Unit

This block converts the lanes of a 128-bit vector between IEEE single precision (32-bit) and IEEE half precision (16-bit) by bit manipulation alone. In the pack direction it narrows two or four single-precision lanes into half-precision fields. The fields are placed at fixed positions in the least significant words of the result. In the unpack direction it widens two or four half-precision fields, taken from those same low words, back into full single-precision lanes.

Word 0 is the most significant 32-bit word, bits [127:96], and holds element X. Words 1, 2 and 3 follow it and hold Y, Z and W. The narrowing step truncates: the discarded mantissa bits have no effect on the result. The narrowing step produces no exception flags. A request is presented with `in_valid` together with the direction and element-count selects. The result appears one clock later on `vec_out` with `out_valid` high. `vec_out` keeps that value until the next request.

Top module: `hvec_conv`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and `vec_out` carries that request's result in the same cycle. While `rst_n` is low, both `out_valid` and `vec_out` are cleared to zero.
- R2: When `in_valid` is low, `vec_out` keeps its previous value whatever the other inputs do.
- R3: Narrowing a single with exponent 0xFF gives a half with the same sign and exponent 0x1F. The half mantissa is 0x200 for a NaN (nonzero single mantissa) and 0 for an infinity.
- R4: Narrowing a finite single whose unbiased exponent e (biased exponent minus 127) is 16 or more gives a half infinity with the same sign.
- R5: Narrowing a single with e below -24 gives a half zero with the same sign. This covers all single zeros and subnormals.
- R6: Narrowing a single with -24 <= e <= -15 gives a half subnormal. Its 10-bit mantissa is the 24-bit significand (implicit one included) shifted right by (-14 - e) + 13.
- R7: Narrowing a single with -14 <= e <= 15 gives half exponent e + 15 and the top 10 single mantissa bits, with the remaining bits truncated.
- R8: Two-element pack (`dir_unpack`=0, `quad_sel`=0) returns {half(X), half(Y)} in bits [31:0] and zeros in bits [127:32]. Words 2 and 3 of the input are ignored.
- R9: Four-element pack (`dir_unpack`=0, `quad_sel`=1) returns {half(X), half(Y)} in bits [63:32], {half(Z), half(W)} in bits [31:0], and zeros in bits [127:64].
- R10: Widening a half with exponent 0x1F gives a single with exponent 0xFF and the same sign. The single mantissa is 0x400000 for a NaN and 0 for an infinity. A half zero widens to a single zero with the same sign.
- R11: Widening a half subnormal shifts its mantissa left k times until bit 10 is set. The single then has exponent 113 - k, mantissa bits [22:13] equal to the low 10 bits of the shifted value, and zeros below.
- R12: Widening a normal half gives single exponent (half exponent + 112) and the half mantissa in bits [22:13], with the low 13 bits zero.
- R13: Two-element unpack (`dir_unpack`=1, `quad_sel`=0) widens input bits [31:16] to word 0 and bits [15:0] to word 1. It writes 0x00000000 to word 2 and 0x3F800000 (1.0) to word 3. Input bits [127:32] are ignored.
- R14: Four-element unpack (`dir_unpack`=1, `quad_sel`=1) widens input bits [63:48], [47:32], [31:16] and [15:0] to words 0, 1, 2 and 3 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| dir_unpack | input | 1 | 0 = narrow (pack), 1 = widen (unpack) |
| quad_sel | input | 1 | 0 = two elements, 1 = four elements |
| vec_in | input | 128 | Source vector, word 0 in bits [127:96] |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| vec_out | output | 128 | Registered result vector |

## Verification
The bench uses the block's fixed single/half geometry, which has no tunable size. Because a half code is only 16 bits, every one of the 65,536 half codes is widened through the four-element unpack, four per request. This covers every NaN, infinity, zero, subnormal shift count and normal exponent. For narrowing, every one of the 256 single exponents is driven with both signs and eight mantissa patterns. The patterns straddle the truncation and subnormal shift boundaries. Shorter directed runs cover the two-element layouts, the constant fill lanes, the ignored upper words and the hold behaviour.

// File: rtl/hvec_conv_pkg.sv
package hvec_conv_pkg;
    localparam int SP_W     = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int HP_W     = 16;
    localparam int HP_EXP_W = 5;
    localparam int HP_MAN_W = 10;
    localparam int LANES    = 4;
    localparam int VEC_W    = SP_W * LANES;

    localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
    localparam int HP_BIAS  = (1 << (HP_EXP_W - 1)) - 1;
    localparam int BIAS_GAP = SP_BIAS - HP_BIAS;
    // biased single exponent thresholds for narrowing
    localparam int OVF_EXP  = SP_BIAS + HP_BIAS + 1;
    localparam int ZERO_EXP = SP_BIAS - HP_BIAS - HP_MAN_W + 1;
    localparam int SUB_EXP  = SP_BIAS - HP_BIAS;
    localparam int MAN_DROP = SP_MAN_W - HP_MAN_W;

    localparam logic [SP_W-1:0] SP_ONE = SP_W'(SP_BIAS) << SP_MAN_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } conv_reg_t;
endpackage

// File: rtl/hvec_narrow.sv
module hvec_narrow
    import hvec_conv_pkg::*;
(
    input  logic [SP_W-1:0] sp_i,
    output logic [HP_W-1:0] hp_o
);
    logic                sgn;
    logic [SP_EXP_W-1:0] ex;
    logic [SP_MAN_W-1:0] mn;
    logic [SP_MAN_W:0]   sig;
    logic [4:0]          sh;
    logic [HP_MAN_W-1:0] sub_man;

    always_comb begin
        sgn     = sp_i[SP_W-1];
        ex      = sp_i[SP_W-2 -: SP_EXP_W];
        mn      = sp_i[SP_MAN_W-1:0];
        sig     = {1'b1, mn};
        sh      = 5'(SP_EXP_W'(SP_BIAS - 1) - ex);
        sub_man = HP_MAN_W'(sig >> sh);
        if (ex == '1) begin
            hp_o = {sgn, {HP_EXP_W{1'b1}}, (mn != '0) ? HP_MAN_W'(1 << (HP_MAN_W - 1)) : HP_MAN_W'(0)};
        end else if (ex >= SP_EXP_W'(OVF_EXP)) begin
            hp_o = {sgn, {HP_EXP_W{1'b1}}, HP_MAN_W'(0)};
        end else if (ex < SP_EXP_W'(ZERO_EXP)) begin
            hp_o = {sgn, (HP_W-1)'(0)};
        end else if (ex <= SP_EXP_W'(SUB_EXP)) begin
            hp_o = {sgn, HP_EXP_W'(0), sub_man};
        end else begin
            hp_o = {sgn, HP_EXP_W'(ex - SP_EXP_W'(BIAS_GAP)), mn[SP_MAN_W-1 -: HP_MAN_W]};
        end
    end
endmodule

// File: rtl/hvec_widen.sv
module hvec_widen
    import hvec_conv_pkg::*;
(
    input  logic [HP_W-1:0] hp_i,
    output logic [SP_W-1:0] sp_o
);
    logic                sgn;
    logic [HP_EXP_W-1:0] ex;
    logic [HP_MAN_W-1:0] mn;
    logic [3:0]          k;
    logic [HP_MAN_W-1:0] norm_man;
    logic [SP_EXP_W-1:0] sub_exp;

    always_comb begin
        sgn = hp_i[HP_W-1];
        ex  = hp_i[HP_W-2 -: HP_EXP_W];
        mn  = hp_i[HP_MAN_W-1:0];
        k   = '0;
        for (int b = 0; b < HP_MAN_W; b++) begin
            if (mn[b]) k = 4'(HP_MAN_W - b);
        end
        norm_man = mn << k;
        sub_exp  = SP_EXP_W'(BIAS_GAP + 1) - SP_EXP_W'(k);
        if (ex == '1) begin
            sp_o = {sgn, {SP_EXP_W{1'b1}}, (mn != '0) ? SP_MAN_W'(1 << (SP_MAN_W - 1)) : SP_MAN_W'(0)};
        end else if (ex == '0 && mn == '0) begin
            sp_o = {sgn, (SP_W-1)'(0)};
        end else if (ex == '0) begin
            sp_o = {sgn, sub_exp, norm_man, MAN_DROP'(0)};
        end else begin
            sp_o = {sgn, SP_EXP_W'(ex) + SP_EXP_W'(BIAS_GAP), mn, MAN_DROP'(0)};
        end
    end
endmodule

// File: rtl/hvec_conv.sv
module hvec_conv
    import hvec_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             dir_unpack,
    input  logic             quad_sel,
    input  logic [VEC_W-1:0] vec_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] vec_out
);
    logic [HP_W-1:0] nar [LANES];
    logic [SP_W-1:0] wid [LANES];
    logic [VEC_W-1:0] res;
    conv_reg_t r_d, r_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // narrowing source: word i, word 0 most significant
        hvec_narrow u_nar (
            .sp_i (vec_in[VEC_W-1-SP_W*i -: SP_W]),
            .hp_o (nar[i])
        );
        // widening source: half field i of the low 64 bits
        hvec_widen u_wid (
            .hp_i (vec_in[HP_W*LANES-1-HP_W*i -: HP_W]),
            .sp_o (wid[i])
        );
    end

    always_comb begin
        case ({dir_unpack, quad_sel})
            2'b00:   res = {(VEC_W-2*HP_W)'(0), nar[0], nar[1]};
            2'b01:   res = {(VEC_W-4*HP_W)'(0), nar[0], nar[1], nar[2], nar[3]};
            2'b10:   res = {wid[2], wid[3], SP_W'(0), SP_ONE};
            default: res = {wid[0], wid[1], wid[2], wid[3]};
        endcase
        r_d     = r_q;
        r_d.vld = in_valid;
        if (in_valid) r_d.data = res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.vld;
    assign vec_out   = r_q.data;
endmodule

// File: rtl/hvec_conv_chk.sv
module hvec_conv_chk
    import hvec_conv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             dir_unpack,
    input logic             quad_sel,
    input logic [VEC_W-1:0] vec_in,
    input logic             out_valid,
    input logic [VEC_W-1:0] vec_out
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(vec_out));
    // R8
    pack_two_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_unpack && !quad_sel) |=> (vec_out[VEC_W-1:32] == '0));
    // R9
    pack_four_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_unpack && quad_sel) |=> (vec_out[VEC_W-1:64] == '0));
    // R13
    unpack_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_unpack && !quad_sel) |=> (vec_out[63:0] == {32'h0, SP_ONE}));
    // R3
    pack_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_unpack && quad_sel && vec_in[30:23] == 8'hFF && vec_in[22:0] != '0)
        |=> (vec_out[14:0] == 15'h7E00));
    // R10
    unpack_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_unpack && quad_sel && vec_in[14:10] == 5'h1F && vec_in[9:0] != '0)
        |=> (vec_out[30:0] == 31'h7FC0_0000));
endmodule

bind hvec_conv hvec_conv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .dir_unpack (dir_unpack),
    .quad_sel   (quad_sel),
    .vec_in     (vec_in),
    .out_valid  (out_valid),
    .vec_out    (vec_out)
);

// File: tb/hvec_conv_tb.sv
module hvec_conv_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         dir_unpack = 1'b0;
    logic         quad_sel = 1'b0;
    logic [127:0] vec_in = '0;
    logic         out_valid;
    logic [127:0] vec_out;
    int           n_chk = 0;
    int           n_err = 0;

    always #10 clk = ~clk;

    hvec_conv u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .dir_unpack (dir_unpack),
        .quad_sel (quad_sel), .vec_in (vec_in), .out_valid (out_valid), .vec_out (vec_out)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] nar_ref(input logic [31:0] f);
        int e;
        logic [23:0] sig;
        e = int'(f[30:23]) - 127;
        sig = {1'b1, f[22:0]};
        if (f[30:23] == 8'hFF)  return {f[31], 5'h1F, (f[22:0] != 0) ? 10'h200 : 10'h0};
        if (e >= 16)            return {f[31], 5'h1F, 10'h0};
        if (e < -24)            return {f[31], 15'h0};
        if (e <= -15)           return {f[31], 5'h0, 10'(sig >> ((-14 - e) + 13))};
        return {f[31], 5'(e + 15), f[22:13]};
    endfunction

    function automatic logic [31:0] wid_ref(input logic [15:0] h);
        int p;
        if (h[14:10] == 5'h1F) return {h[15], 8'hFF, (h[9:0] != 0) ? 23'h400000 : 23'h0};
        if (h[14:0] == 0)      return {h[15], 31'h0};
        if (h[14:10] == 0) begin
            p = 0;
            for (int b = 0; b < 10; b++) if (h[b]) p = b;
            return {h[15], 8'(p + 103), 23'((32'(h[9:0]) << (23 - p)) & 32'h7FFFFF)};
        end
        return {h[15], 8'(int'(h[14:10]) + 112), h[9:0], 13'h0};
    endfunction

    function automatic string nar_tag(input logic [31:0] f);
        if (f[30:23] == 8'hFF) return "R3";
        if (f[30:23] >= 8'd143) return "R4";
        if (f[30:23] < 8'd103) return "R5";
        if (f[30:23] <= 8'd112) return "R6";
        return "R7";
    endfunction

    function automatic string wid_tag(input logic [15:0] h);
        if (h[14:10] == 5'h1F || h[14:0] == 0) return "R10";
        if (h[14:10] == 0) return "R11";
        return "R12";
    endfunction

    function automatic logic [22:0] man_pat(input int i);
        case (i)
            0: return 23'h000000;
            1: return 23'h000001;
            2: return 23'h400000;
            3: return 23'h7FFFFF;
            4: return 23'h001FFF;
            5: return 23'h002000;
            6: return 23'h155555;
            default: return 23'h2AAAAA;
        endcase
    endfunction

    // drive one request at a negedge; return at the next negedge with the result registered
    task automatic run_op(input logic d, input logic q, input logic [127:0] v);
        dir_unpack = d;
        quad_sel   = q;
        vec_in     = v;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [127:0] v, held;
        logic [31:0]  w [4];
        logic [15:0]  hx;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset valid", 128'(out_valid), 128'h0);
        chk("R1 reset data", vec_out, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: 1.0 and -2.5 narrow, two-element layout R8
        run_op(1'b0, 1'b0, {32'h3F80_0000, 32'hC020_0000, 32'hDEAD_BEEF, 32'h1234_5678});
        chk("R1 valid after request", 128'(out_valid), 128'h1);
        chk("R8 two-element pack", vec_out, {96'h0, 16'h3C00, 16'hC100});
        @(negedge clk);
        chk("R1 valid drops", 128'(out_valid), 128'h0);

        // R2: hold with changed inputs and no strobe
        held = vec_out;
        dir_unpack = 1'b1; quad_sel = 1'b1; vec_in = {4{32'hA5A5_5A5A}};
        @(negedge clk);
        chk("R2 hold", vec_out, held);

        // R14: directed four-element unpack placement
        run_op(1'b1, 1'b1, {64'hFFFF_FFFF_FFFF_FFFF, 16'h3C00, 16'hC000, 16'h0000, 16'h7C00});
        chk("R14 four-element unpack", vec_out, {32'h3F80_0000, 32'hC000_0000, 32'h0, 32'h7F80_0000});

        // R13: two-element unpack with junk upper words
        run_op(1'b1, 1'b0, {96'hCAFE_F00D_1357_9BDF_2468_ACE0, 16'h3800, 16'h0001});
        chk("R13 two-element unpack", vec_out, {32'h3F00_0000, 32'h3380_0000, 32'h0, 32'h3F80_0000});

        // exhaustive widen sweep through four-element unpack
        for (int base = 0; base < 65536; base += 4) begin
            v = {64'h0, 16'(base), 16'(base + 1), 16'(base + 2), 16'(base + 3)};
            run_op(1'b1, 1'b1, v);
            for (int j = 0; j < 4; j++) begin
                hx = 16'(base + j);
                chk(wid_tag(hx), 128'(vec_out[127 - 32*j -: 32]), 128'(wid_ref(hx)));
            end
        end

        // narrow sweep: all exponents, both signs, eight mantissa patterns
        for (int ex = 0; ex < 256; ex++) begin
            for (int s = 0; s < 2; s++) begin
                for (int g = 0; g < 2; g++) begin
                    for (int j = 0; j < 4; j++) w[j] = {1'(s), 8'(ex), man_pat(g*4 + j)};
                    run_op(1'b0, 1'b1, {w[0], w[1], w[2], w[3]});
                    chk("R9 four-element pack upper", 128'(vec_out[127:64]), 128'h0);
                    for (int j = 0; j < 4; j++)
                        chk(nar_tag(w[j]), 128'(vec_out[63 - 16*j -: 16]), 128'(nar_ref(w[j])));
                end
                // two-element pack: words 2 and 3 must not matter (R8)
                w[0] = {1'(s), 8'(ex), man_pat(ex % 8)};
                w[1] = {1'(~s), 8'(255 - ex), man_pat((ex + 3) % 8)};
                run_op(1'b0, 1'b0, {w[0], w[1], 32'(ex * 7919), 32'hFFFF_FFFF});
                chk("R8 two-element pack sweep", vec_out, {96'h0, nar_ref(w[0]), nar_ref(w[1])});
            end
        end

        // two-element unpack sweep over a spread of half codes (R13)
        for (int i = 0; i < 512; i++) begin
            logic [15:0] a, b;
            a = 16'(i * 131);
            b = 16'(65535 - i * 127);
            run_op(1'b1, 1'b0, {32'(i), 32'hFFFF_0000, 32'h7F80_0001, a, b});
            chk("R13 two-element unpack sweep", vec_out, {wid_ref(a), wid_ref(b), 32'h0, 32'h3F80_0000});
        end

        // R1: reset clears a non-zero result
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears data", vec_out, 128'h0);
        finish_run();
    end
endmodule